// File: doc/BRIEF.md
# Delay-locked loop lock controller

This block is the digital control for a delay-locked loop whose master delay line is made of a chain of identical delay units. A phase comparator outside the block compares the output of the line with a free-running reference clock. It reports either "up" (add delay) or "down" (remove delay). The controller turns these results into a 5-bit delay command. That command is shared by every delay unit, and its value is a gate index from 0 (minimum delay) to 23 (maximum delay). The delay cells and the comparator are outside the block.

Lock mode is meant for reference clocks of 50 MHz and faster. The loop runs as a state machine with three states:

- ST_IDLE holds the command at minimum.
- ST_SEARCH steps the command by one per comparator decision.
- ST_TRACK is entered once the comparator has reversed direction four times in a row. It raises the locked flag and keeps following slow voltage and temperature drift. A change of reference frequency is not followed and needs a new lock sequence.

The transitions are:

- T_START (ST_IDLE to ST_SEARCH) while start-lock is high.
- T_LOCK (ST_SEARCH to ST_TRACK) on the fourth consecutive reversal.
- T_ABORT (ST_SEARCH or ST_TRACK to ST_IDLE) when start-lock goes low.

Start-lock must be low during reset and must stay high for as long as the loop is in use. A new lock is started by taking start-lock low and then high again.

Bypass mode is meant for slower clocks. When bypass is enabled, a software code forces the delay command directly, and the loop keeps running unseen behind it. Code 0 is reserved. The block treats code 0 as minimum delay and raises an error indication.

Top module: `dll_lock_ctrl`

## Requirements
- R1: While rst_n is low, dly_cmd is 0, locked is 0 and, with byp_en low, byp_err is 0.
- R2: While start_lock is low, the state machine stays in ST_IDLE. Comparator decisions leave dly_cmd at 0 and locked at 0.
- R3: In lock mode, a decision with only cmp_up high raises the command by 1, and a decision with only cmp_down high lowers it by 1. A decision with both high or both low changes nothing. The comparator inputs pass through two synchroniser flops, so a decision sampled at one rising edge first appears on dly_cmd after the third rising edge.
- R4: The loop command never leaves the range 0 to 23. An "up" decision at 23 and a "down" decision at 0 leave it unchanged, in both ST_SEARCH and ST_TRACK.
- R5: In ST_SEARCH, a decision whose direction is opposite to the previous decision counts as a reversal, and a decision in the same direction resets the count to 0. The first decision after ST_IDLE never counts. The fourth consecutive reversal moves the machine to ST_TRACK and sets locked from the same clock edge.
- R6: In ST_TRACK, locked stays 1 and decisions keep adjusting the command as in R3 and R4.
- R7: At the first rising edge with start_lock low, the machine returns to ST_IDLE. From that edge, locked is 0 and the loop command is 0. A later lock needs a full new reversal sequence.
- R8: With byp_en high, dly_cmd follows byp_cmd directly, without a clock. Codes 1 to 24 give gate code−1, and codes 25 to 31 give gate 23.
- R9: With byp_en high and byp_cmd equal to 0, dly_cmd is 0 and byp_err is 1. byp_err is 0 whenever byp_en is low or the code is nonzero.
- R10: Bypass does not disturb the loop. locked keeps its value while byp_en is high, and dly_cmd shows the loop command again as soon as byp_en goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_lock | input | 1 | Level request to run and hold the lock loop |
| cmp_up | input | 1 | Comparator result: more delay needed (asynchronous) |
| cmp_down | input | 1 | Comparator result: less delay needed (asynchronous) |
| byp_en | input | 1 | Select the bypass code instead of the loop command |
| byp_cmd | input | 5 | Bypass code, 1 to 24 = gate 0 to 23, 25 to 31 saturate, 0 reserved |
| dly_cmd | output | 5 | Delay gate index applied to all delay units |
| locked | output | 1 | High in ST_TRACK |
| byp_err | output | 1 | Reserved bypass code 0 in use |

## Verification
On every cycle, the assertions check the following: the loop command stays in range, it moves by at most one step per cycle, locked can only rise on a comparator decision, and dropping start_lock clears the loop from the next edge. In bypass they check the code-0 error mapping and the saturation of high codes. Whether the fourth reversal, and no earlier decision, produces lock, and whether same-direction decisions restart the count, can only be shown by the bench's decision sequences. The same holds for the exact three-edge latency and for the loop value coming back after bypass.

// File: rtl/dll_pkg.sv
package dll_pkg;
    localparam int CMD_W      = 5;
    localparam int GATE_COUNT = 24;
    localparam int ALT_LOCK   = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_TRACK  = 2'd2
    } lock_state_t;
endpackage

// File: rtl/dll_sync2.sv
module dll_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage1[gi] <= 1'b0;
                    stage2[gi] <= 1'b0;
                end else begin
                    stage1[gi] <= d_async[gi];
                    stage2[gi] <= stage1[gi];
                end
            end
        end
    endgenerate

    assign d_sync = stage2;
endmodule

// File: rtl/dll_byp_decode.sv
module dll_byp_decode #(
    parameter int CMD_W      = 5,
    parameter int GATE_COUNT = 24
) (
    input  logic [CMD_W-1:0] code,
    output logic [CMD_W-1:0] gate,
    output logic             reserved
);
    localparam logic [CMD_W-1:0] TOP_CODE = CMD_W'(GATE_COUNT);
    localparam logic [CMD_W-1:0] MAX_GATE = CMD_W'(GATE_COUNT - 1);
    localparam logic [CMD_W-1:0] ONE      = CMD_W'(1);

    always_comb begin
        reserved = 1'b0;
        if (code == '0) begin
            gate     = '0;
            reserved = 1'b1;
        end else if (code > TOP_CODE) begin
            gate = MAX_GATE;
        end else begin
            gate = code - ONE;
        end
    end
endmodule

// File: rtl/dll_lock_fsm.sv
module dll_lock_fsm
    import dll_pkg::*;
#(
    parameter int CMD_W      = 5,
    parameter int GATE_COUNT = 24,
    parameter int ALT_LOCK   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_lock,
    input  logic             dec_up,
    input  logic             dec_dn,
    output logic [CMD_W-1:0] loop_cmd,
    output logic             locked
);
    localparam int               CNT_W    = $clog2(ALT_LOCK + 1);
    localparam logic [CMD_W-1:0] MAX_CMD  = CMD_W'(GATE_COUNT - 1);
    localparam logic [CMD_W-1:0] ONE      = CMD_W'(1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ALT_LOCK - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    lock_state_t      state, state_nxt;
    logic [CMD_W-1:0] cmd_q, cmd_nxt;
    logic [CNT_W-1:0] rev_cnt;
    logic             last_up;
    logic             dir_valid;
    logic             decision;
    logic             reversal;
    logic             lock_hit;

    // one decision per cycle when exactly one comparator output is high
    assign decision = dec_up ^ dec_dn;
    assign reversal = decision && dir_valid && (dec_up != last_up);
    assign lock_hit = reversal && (rev_cnt == CNT_LAST);

    always_comb begin
        cmd_nxt = cmd_q;
        if (decision) begin
            if (dec_up && cmd_q < MAX_CMD) begin
                cmd_nxt = cmd_q + ONE;
            end else if (dec_dn && cmd_q != '0) begin
                cmd_nxt = cmd_q - ONE;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_lock) state_nxt = ST_SEARCH;          // T_START
            end
            ST_SEARCH: begin
                if (!start_lock)   state_nxt = ST_IDLE;         // T_ABORT
                else if (lock_hit) state_nxt = ST_TRACK;        // T_LOCK
            end
            ST_TRACK: begin
                if (!start_lock) state_nxt = ST_IDLE;           // T_ABORT
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // command and reversal counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            rev_cnt   <= '0;
            last_up   <= 1'b0;
            dir_valid <= 1'b0;
        end else if (state == ST_IDLE || !start_lock) begin
            cmd_q     <= '0;
            rev_cnt   <= '0;
            last_up   <= 1'b0;
            dir_valid <= 1'b0;
        end else begin
            cmd_q <= cmd_nxt;
            if (state == ST_SEARCH && decision) begin
                last_up   <= dec_up;
                dir_valid <= 1'b1;
                if (reversal) rev_cnt <= rev_cnt + CNT_ONE;
                else          rev_cnt <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        loop_cmd = cmd_q;
        unique case (state)
            ST_TRACK: locked = 1'b1;
            default:  locked = 1'b0;
        endcase
    end

    // R4: loop command stays within the gate range
    assert_cmd_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        loop_cmd <= MAX_CMD);

    // R3: at most one step per cycle while running
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_lock && $past(start_lock)) |->
        (loop_cmd == $past(loop_cmd) || loop_cmd == $past(loop_cmd) + ONE ||
         loop_cmd == $past(loop_cmd) - ONE));

    // R5: lock only follows a comparator decision
    assert_lock_on_decision_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(dec_up) ^ $past(dec_dn)));

    // R7: dropping start-lock clears the loop at the next edge
    assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_lock |=> (!locked && loop_cmd == '0));
endmodule

// File: rtl/dll_lock_ctrl.sv
module dll_lock_ctrl
    import dll_pkg::*;
(
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             start_lock,
    input  logic             cmp_up,
    input  logic             cmp_down,
    input  logic             byp_en,
    input  logic [CMD_W-1:0] byp_cmd,
    output logic [CMD_W-1:0] dly_cmd,
    output logic             locked,
    output logic             byp_err
);
    localparam logic [CMD_W-1:0] MAX_CMD  = CMD_W'(GATE_COUNT - 1);
    localparam logic [CMD_W-1:0] TOP_CODE = CMD_W'(GATE_COUNT);

    logic [1:0]       cmp_sync;
    logic [CMD_W-1:0] loop_cmd;
    logic [CMD_W-1:0] byp_gate;
    logic             byp_reserved;

    dll_sync2 #(.W(2)) u_sync (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .d_async ({cmp_up, cmp_down}),
        .d_sync  (cmp_sync)
    );

    dll_lock_fsm #(
        .CMD_W      (CMD_W),
        .GATE_COUNT (GATE_COUNT),
        .ALT_LOCK   (ALT_LOCK)
    ) u_fsm (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .start_lock (start_lock),
        .dec_up     (cmp_sync[1]),
        .dec_dn     (cmp_sync[0]),
        .loop_cmd   (loop_cmd),
        .locked     (locked)
    );

    dll_byp_decode #(
        .CMD_W      (CMD_W),
        .GATE_COUNT (GATE_COUNT)
    ) u_byp (
        .code     (byp_cmd),
        .gate     (byp_gate),
        .reserved (byp_reserved)
    );

    assign dly_cmd = byp_en ? byp_gate : loop_cmd;
    assign byp_err = byp_en & byp_reserved;

    // R9: reserved code drives minimum delay
    assert_err_min_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
        byp_err |-> (dly_cmd == '0));

    // R8: codes above the gate count saturate at maximum delay
    assert_byp_sat_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (byp_en && byp_cmd > TOP_CODE) |-> (dly_cmd == MAX_CMD));
endmodule

// File: tb/tb_dll_lock_ctrl.sv
module tb_dll_lock_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    // {code, expected gate, expected error}
    localparam logic [10:0] BYP_VEC [NVEC] = '{
        {5'd0,  5'd0,  1'b1}, {5'd1,  5'd0,  1'b0}, {5'd2,  5'd1,  1'b0},
        {5'd12, 5'd11, 1'b0}, {5'd23, 5'd22, 1'b0}, {5'd24, 5'd23, 1'b0},
        {5'd25, 5'd23, 1'b0}, {5'd26, 5'd23, 1'b0}, {5'd30, 5'd23, 1'b0},
        {5'd31, 5'd23, 1'b0}
    };

    logic       clk_ref = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_lock = 1'b0;
    logic       cmp_up = 1'b0;
    logic       cmp_down = 1'b0;
    logic       byp_en = 1'b0;
    logic [4:0] byp_cmd = 5'd0;
    logic [4:0] dly_cmd;
    logic       locked;
    logic       byp_err;

    int errors = 0;
    int checks = 0;

    int m_cmd = 0;
    int m_cnt = 0;
    bit m_last = 1'b0;
    bit m_valid = 1'b0;
    bit m_locked = 1'b0;

    dll_lock_ctrl dut (
        .clk_ref (clk_ref), .rst_n (rst_n), .start_lock (start_lock),
        .cmp_up (cmp_up), .cmp_down (cmp_down), .byp_en (byp_en),
        .byp_cmd (byp_cmd), .dly_cmd (dly_cmd), .locked (locked),
        .byp_err (byp_err)
    );

    always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cmd = 0; m_cnt = 0; m_last = 1'b0; m_valid = 1'b0; m_locked = 1'b0;
    endtask

    task automatic decide(input bit up, input bit dn, input string req);
        @(negedge clk_ref);
        cmp_up = up; cmp_down = dn;
        @(negedge clk_ref);
        cmp_up = 1'b0; cmp_down = 1'b0;
        repeat (4) @(negedge clk_ref);
        if (start_lock && (up ^ dn)) begin
            if (up && m_cmd < 23) m_cmd++;
            else if (dn && m_cmd > 0) m_cmd--;
            if (!m_locked) begin
                if (m_valid && up != m_last) m_cnt++;
                else m_cnt = 0;
                m_last = up; m_valid = 1'b1;
                if (m_cnt == 4) m_locked = 1'b1;
            end
        end
        chk({req, " dly_cmd"}, dly_cmd, m_cmd);
        chk({req, " locked"}, locked, m_locked);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        #(CLK_PERIOD * 3);
        chk("R1 dly_cmd", dly_cmd, 0);
        chk("R1 locked", locked, 0);
        chk("R1 byp_err", byp_err, 0);
        @(negedge clk_ref); rst_n = 1'b1;
        repeat (2) @(negedge clk_ref);

        // R2: idle ignores decisions
        decide(1, 0, "R2");
        decide(1, 0, "R2");
        decide(0, 1, "R2");

        // R8 R9: bypass decode table
        byp_en = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            byp_cmd = BYP_VEC[i][10:6];
            #1;
            chk($sformatf("R8 code %0d", BYP_VEC[i][10:6]), dly_cmd, BYP_VEC[i][5:1]);
            chk($sformatf("R9 code %0d err", BYP_VEC[i][10:6]), byp_err, BYP_VEC[i][0]);
        end
        byp_en = 1'b0; byp_cmd = 5'd0;
        #1; chk("R9 err off when bypass off", byp_err, 0);

        // R3: exact latency of one up decision
        @(negedge clk_ref); start_lock = 1'b1;
        repeat (2) @(negedge clk_ref);
        cmp_up = 1'b1;
        @(posedge clk_ref); #1 cmp_up = 1'b0;
        @(posedge clk_ref); #1 chk("R3 no change after 2 edges", dly_cmd, 0);
        @(posedge clk_ref); #1 chk("R3 change after 3rd edge", dly_cmd, 1);
        m_cmd = 1; m_last = 1'b1; m_valid = 1'b1; m_cnt = 0;
        repeat (2) @(negedge clk_ref);

        // R3 R5: stepping and reversal counting
        decide(1, 0, "R3 up");
        decide(1, 0, "R3 up");
        decide(1, 1, "R3 both");
        decide(0, 0, "R3 none");
        decide(0, 1, "R5 rev1");
        decide(1, 0, "R5 rev2");
        decide(0, 1, "R5 rev3");
        decide(0, 1, "R5 same resets");
        decide(1, 0, "R5 rev1b");
        decide(0, 1, "R5 rev2b");
        decide(1, 0, "R5 rev3b");
        chk("R5 not yet locked", locked, 0);
        decide(0, 1, "R5 rev4 locks");
        chk("R5 locked", locked, 1);

        // R6 R4: tracking and clamp at zero
        decide(1, 0, "R6 track up");
        for (int i = 0; i < 5; i++) decide(0, 1, "R4 track clamp low");
        chk("R4 at zero", dly_cmd, 0);

        // R7: abort
        @(negedge clk_ref); start_lock = 1'b0;
        @(negedge clk_ref);
        model_reset();
        chk("R7 locked cleared", locked, 0);
        chk("R7 cmd cleared", dly_cmd, 0);

        // R4: upper clamp in search, then relock
        @(negedge clk_ref); start_lock = 1'b1;
        repeat (2) @(negedge clk_ref);
        for (int i = 0; i < 26; i++) decide(1, 0, "R4 clamp high");
        chk("R4 at max", dly_cmd, 23);
        chk("R7 relock needs sequence", locked, 0);
        decide(0, 1, "R5 relock1");
        decide(1, 0, "R5 relock2");
        decide(0, 1, "R5 relock3");
        decide(1, 0, "R5 relock4");
        chk("R5 relocked", locked, 1);

        // R10: bypass over a locked loop
        @(negedge clk_ref); byp_en = 1'b1; byp_cmd = 5'd5;
        repeat (3) @(negedge clk_ref);
        chk("R10 bypass value", dly_cmd, 4);
        chk("R10 locked kept", locked, 1);
        byp_en = 1'b0;
        #1 chk("R10 loop value back", dly_cmd, 23);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule